// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block sits between a simple request/response host port and an 8-bit asynchronous NAND flash device. The host picks one operation: page read, page program, block erase, status read or device reset. The block then produces the full command, address and data cycle train on the flash bus. It drives the latch strobes and the shared data byte. It waits on the ready/busy line between the two halves of an operation, and it reports a result code with a one-cycle completion pulse.

Every bus interval is a run-time count of system clock cycles. This covers the strobe low and high widths, the delay before ready/busy is polled, the gap after ready returns, the write-to-read turnaround before a status byte, and the busy timeout. Read data leaves the block one byte per strobe on `rd_data`/`rd_valid`. Program data is pulled from the host one byte at a time, and `wr_take` marks each byte the block has taken.

Top module: `nand_seq`

## Requirements
- R1: While reset is held, CE#, WE# and RE# are high, CLE, ALE and the data driver enable are low, `req_ready` is high and `done` is low.
- R2: Each command byte is sent with CLE high and ALE low. The byte, CLE and ALE do not change in the cycle where WE# rises. The codes are: read 00h then 30h, program 80h then 10h, erase 60h then D0h, status 70h, reset FFh.
- R3: A read or a program sends four address bytes with ALE high and CLE low. The order is column[7:0], then {4'b0000, column[11:8]}, then page[7:0], then page[15:8].
- R4: An erase sends 60h, then page[7:0] and page[15:8], then D0h. It waits for ready and then reads status with 70h. The column input is ignored.
- R5: After 30h the block waits `t_wb` cycles, then waits until ready/busy is high, then waits at least `t_rr` more cycles before the first RE# fall. It then gives exactly `req_len` RE# pulses, and each sampled byte appears in order on `rd_data` with a one-cycle `rd_valid`.
- R6: A program sends `req_len` data bytes taken from `wr_data` in order, with one `wr_take` pulse per byte. The data bytes are driven with CLE and ALE both low. The block then sends 10h, waits for ready and reads status with 70h.
- R7: If ready/busy stays low for more than `t_to` cycles after the `t_wb` wait, the operation ends with result 2 and CE# goes high.
- R8: Every WE# and RE# low pulse lasts exactly `t_wp` cycles. Each pulse is preceded by at least `t_wh` cycles high.
- R9: The operation codes are 0 read, 1 program, 2 erase, 3 status, 4 reset. The result codes are 0 ok, 1 fail, 2 timeout, 3 bad operation. Codes 5 to 7 end with result 3 and cause no bus activity.
- R10: A status request sends 70h and waits at least `t_whr` cycles from the WE# rise to the RE# fall. It then makes one read and returns the byte on `rd_data` with result 0. For program and erase, result is 1 when bit 0 of the status byte is set and 0 otherwise, and the status byte is also shown on `rd_data`.
- R11: A reset request sends only FFh, then waits for ready and ends with result 0.
- R12: CLE and ALE are never high together, WE# and RE# are never low together, and the data driver is never enabled while RE# is low.
- R13: `done` lasts one cycle. In that cycle CE# is high and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 3 | Operation code |
| req_col | input | 12 | Column address |
| req_page | input | 16 | Page address (block address in the upper bits) |
| req_len | input | LW | Data byte count for read and program, at least 1 |
| wr_data | input | 8 | Next program byte |
| wr_take | output | 1 | Pulse: `wr_data` was taken |
| rd_data | output | 8 | Read or status byte |
| rd_valid | output | 1 | Pulse: `rd_data` is new |
| done | output | 1 | Pulse: operation finished |
| result | output | 2 | Result code, valid with `done` |
| t_wp | input | CW | Strobe low width, cycles, at least 1 |
| t_wh | input | CW | Strobe high width, cycles, at least 1 |
| t_whr | input | CW | WE# rise to RE# fall gap for status |
| t_rr | input | CW | Ready to next strobe gap |
| t_wb | input | CW | Delay before ready/busy is polled |
| t_to | input | TW | Busy timeout, cycles |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Bus driver enable |
| nand_dq_in | input | 8 | Byte sampled from the bus |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The assertions assume that the timing inputs stay constant during an operation and that `t_wp` and `t_wh` are at least 1. They also assume that `req_len` is at least 1 for read and program, and that the flash pulls ready/busy low within `t_wb` cycles after a command that starts an internal operation. The bench keeps to this in three ways. It sets all timing inputs once, before reset is released. Every table entry uses a length of 1 or more. Its flash model drops ready/busy two cycles after the starting command, while `t_wb` is set to six cycles.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int CW = 8,
  parameter int TW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [11:0]   req_col,
  input  logic [15:0]   req_page,
  input  logic [LW-1:0] req_len,
  input  logic [7:0]    wr_data,
  output logic          wr_take,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          done,
  output logic [1:0]    result,
  input  logic [CW-1:0] t_wp,
  input  logic [CW-1:0] t_wh,
  input  logic [CW-1:0] t_whr,
  input  logic [CW-1:0] t_rr,
  input  logic [CW-1:0] t_wb,
  input  logic [TW-1:0] t_to,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [7:0]    nand_dq_in,
  input  logic          nand_rb
);

  localparam logic [2:0] OP_RD = 3'd0, OP_PG = 3'd1, OP_ER = 3'd2, OP_ST = 3'd3, OP_RS = 3'd4;
  localparam logic [1:0] R_OK = 2'd0, R_FAIL = 2'd1, R_TO = 2'd2, R_BAD = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DATW, S_CMD2, S_WB, S_BUSY,
    S_RR, S_DATR, S_STC, S_WHR, S_STR
  } st_t;

  st_t           st;
  logic [2:0]    op;
  logic [11:0]   col;
  logic [15:0]   page;
  logic [LW-1:0] len, idx;
  logic [1:0]    ph;
  logic [CW-1:0] cnt, cnt_nx;
  logic [TW-1:0] tmo;
  logic [7:0]    wbyte, bus_byte;
  logic [1:0]    rb_q;
  logic          wr_st, rd_st, last_addr, last_byte;

  assign wr_st     = st inside {S_CMD1, S_ADDR, S_DATW, S_CMD2, S_STC};
  assign rd_st     = st inside {S_DATR, S_STR};
  assign cnt_nx    = cnt + 1'b1;
  assign last_addr = (op == OP_ER) ? (idx == LW'(1)) : (idx == LW'(3));
  assign last_byte = (idx == len - 1'b1);

  assign req_ready   = (st == S_IDLE);
  assign nand_ce_n   = (st == S_IDLE);
  assign nand_cle    = st inside {S_CMD1, S_CMD2, S_STC};
  assign nand_ale    = (st == S_ADDR);
  assign nand_we_n   = !(wr_st && ph == 2'd1);
  assign nand_re_n   = !(rd_st && ph == 2'd1);
  assign nand_dq_oe  = wr_st;
  assign nand_dq_out = bus_byte;

  always_comb begin
    bus_byte = 8'h00;
    case (st)
      S_CMD1:
        case (op)
          OP_RD:   bus_byte = 8'h00;
          OP_PG:   bus_byte = 8'h80;
          OP_ER:   bus_byte = 8'h60;
          OP_ST:   bus_byte = 8'h70;
          default: bus_byte = 8'hFF;
        endcase
      S_ADDR:
        if (op == OP_ER) bus_byte = idx[0] ? page[15:8] : page[7:0];
        else
          case (idx[1:0])
            2'd0:    bus_byte = col[7:0];
            2'd1:    bus_byte = {4'h0, col[11:8]};
            2'd2:    bus_byte = page[7:0];
            default: bus_byte = page[15:8];
          endcase
      S_CMD2:  bus_byte = (op == OP_RD) ? 8'h30 : (op == OP_PG) ? 8'h10 : 8'hD0;
      S_STC:   bus_byte = 8'h70;
      S_DATW:  bus_byte = wbyte;
      default: bus_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_RD; col <= '0; page <= '0; len <= '0; idx <= '0;
      ph <= 2'd0; cnt <= '0; tmo <= '0; wbyte <= 8'h00; rb_q <= 2'b00;
      rd_data <= 8'h00; rd_valid <= 1'b0; wr_take <= 1'b0; done <= 1'b0; result <= R_OK;
    end else begin
      done <= 1'b0; rd_valid <= 1'b0; wr_take <= 1'b0;
      rb_q <= {rb_q[0], nand_rb};
      case (st)
        S_IDLE:
          if (req_valid) begin
            op <= req_op; col <= req_col; page <= req_page; len <= req_len;
            idx <= '0; cnt <= '0; ph <= 2'd0;
            if (req_op > OP_RS) begin
              done <= 1'b1; result <= R_BAD;
            end else st <= S_CMD1;
          end
        S_WB:
          if (cnt == t_wb) begin st <= S_BUSY; cnt <= '0; tmo <= '0; end
          else cnt <= cnt_nx;
        S_BUSY:
          if (rb_q[1]) begin st <= S_RR; cnt <= '0; end
          else if (tmo == t_to) begin st <= S_IDLE; done <= 1'b1; result <= R_TO; end
          else tmo <= tmo + 1'b1;
        S_RR:
          if (cnt == t_rr) begin
            cnt <= '0; ph <= 2'd0; idx <= '0;
            if (op == OP_RD) st <= S_DATR;
            else if (op == OP_RS) begin st <= S_IDLE; done <= 1'b1; result <= R_OK; end
            else st <= S_STC;
          end else cnt <= cnt_nx;
        S_WHR:
          if (cnt == t_whr) begin st <= S_STR; cnt <= '0; ph <= 2'd0; end
          else cnt <= cnt_nx;
        default:
          case (ph)
            2'd0:
              if (cnt_nx == t_wh) begin ph <= 2'd1; cnt <= '0; end
              else cnt <= cnt_nx;
            2'd1:
              if (cnt_nx == t_wp) begin
                ph <= 2'd2; cnt <= '0;
                if (rd_st) begin rd_data <= nand_dq_in; rd_valid <= 1'b1; end
              end else cnt <= cnt_nx;
            default: begin
              ph <= 2'd0;
              case (st)
                S_CMD1:
                  if (op == OP_ST) st <= S_WHR;
                  else if (op == OP_RS) st <= S_WB;
                  else st <= S_ADDR;
                S_ADDR:
                  if (last_addr) begin
                    idx <= '0;
                    if (op == OP_PG) begin st <= S_DATW; wbyte <= wr_data; wr_take <= 1'b1; end
                    else st <= S_CMD2;
                  end else idx <= idx + 1'b1;
                S_DATW:
                  if (last_byte) st <= S_CMD2;
                  else begin idx <= idx + 1'b1; wbyte <= wr_data; wr_take <= 1'b1; end
                S_CMD2: st <= S_WB;
                S_STC:  st <= S_WHR;
                S_DATR:
                  if (last_byte) begin st <= S_IDLE; done <= 1'b1; result <= R_OK; end
                  else idx <= idx + 1'b1;
                S_STR: begin
                  st <= S_IDLE; done <= 1'b1;
                  result <= (op != OP_ST && rd_data[0]) ? R_FAIL : R_OK;
                end
                default: st <= S_IDLE;
              endcase
            end
          endcase
      endcase
    end
  end

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_cle_ale_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_oe_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_out)));
  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nand_ce_n && req_ready));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_rdv_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!nand_re_n));

endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  localparam int T_WP = 3, T_WH = 2, T_WHR = 7, T_RR = 2, T_WB = 6, T_TO = 60;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] col;
    logic [15:0] page;
    logic [11:0] len;
    logic [7:0]  stat;
    logic [1:0]  res;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{3'd0, 12'h123, 16'hBEEF, 12'd4, 8'hC0, 2'd0},
    '{3'd0, 12'h8F0, 16'h0001, 12'd3, 8'hC0, 2'd0},
    '{3'd1, 12'h010, 16'h1234, 12'd5, 8'hC0, 2'd0},
    '{3'd1, 12'h7A5, 16'h00FF, 12'd2, 8'hC1, 2'd1},
    '{3'd2, 12'hABC, 16'h5A40, 12'd1, 8'hC0, 2'd0},
    '{3'd2, 12'h000, 16'h0080, 12'd1, 8'hE1, 2'd1},
    '{3'd3, 12'h000, 16'h0000, 12'd1, 8'hE0, 2'd0},
    '{3'd4, 12'h000, 16'h0000, 12'd1, 8'hE0, 2'd0},
    '{3'd5, 12'h003, 16'h0003, 12'd1, 8'h00, 2'd3}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, wr_take, rd_valid, done;
  logic [2:0]  req_op;
  logic [11:0] req_col, req_len;
  logic [15:0] req_page;
  logic [7:0]  wr_data, rd_data, nand_dq_out;
  logic [1:0]  result;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb = 1'b1;

  nand_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_page(req_page), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .result(result),
    .t_wp(8'(T_WP)), .t_wh(8'(T_WH)), .t_whr(8'(T_WHR)), .t_rr(8'(T_RR)),
    .t_wb(8'(T_WB)), .t_to(16'(T_TO)),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  function automatic logic [7:0] pat(input logic [15:0] p, input logic [11:0] c);
    return (c[7:0] ^ p[7:0]) + p[15:8] + {4'h0, c[11:8]};
  endfunction

  function automatic logic [7:0] wpat(input logic [11:0] c, input int i);
    return (c[7:0] + 8'(i * 37)) ^ 8'h5A;
  endfunction

  // flash model: bus trace, read data, ready/busy
  logic [9:0]  tr [0:63];
  logic [9:0]  ex [0:63];
  int          trn = 0, tr_clr = 0, tr_seen = 0;
  logic [7:0]  abuf [0:3];
  int          acnt = 0, kicks = 0, rd_ep = 0, rd_seen = 0, roff = 0;
  logic [7:0]  last_cmd = 8'hFF, stat_val = 8'hC0;
  logic [11:0] mcol = '0;
  logic [15:0] mpage = '0;

  always @(posedge nand_we_n) if (nand_ce_n === 1'b0) begin
    if (tr_seen != tr_clr) begin tr_seen = tr_clr; trn = 0; end
    if (nand_cle && !nand_ale) begin
      last_cmd = nand_dq_out; acnt = 0;
      if (trn < 64) tr[trn] = {2'd1, nand_dq_out};
      trn++;
      if (nand_dq_out == 8'h30) begin
        mcol = {abuf[1][3:0], abuf[0]}; mpage = {abuf[3], abuf[2]}; rd_ep++;
      end
      if (nand_dq_out inside {8'h30, 8'h10, 8'hD0, 8'hFF}) kicks++;
    end else if (nand_ale && !nand_cle) begin
      if (acnt < 4) abuf[acnt] = nand_dq_out;
      acnt++;
      if (trn < 64) tr[trn] = {2'd2, nand_dq_out};
      trn++;
    end else if (!nand_cle && !nand_ale) begin
      if (trn < 64) tr[trn] = {2'd3, nand_dq_out};
      trn++;
    end
  end

  always @(negedge nand_re_n) if (nand_ce_n === 1'b0) begin
    if (last_cmd == 8'h70) nand_dq_in = stat_val;
    else begin
      if (rd_seen != rd_ep) begin rd_seen = rd_ep; roff = 0; end
      nand_dq_in = pat(mpage, mcol + 12'(roff));
      roff++;
    end
  end

  int kseen = 0, bdly = 0, bcnt = 0, busy_len = 20;
  always @(negedge clk) begin
    if (kicks != kseen) begin kseen = kicks; bdly = 2; end
    else if (bdly > 0) begin
      bdly--;
      if (bdly == 0) begin nand_rb = 1'b0; bcnt = 0; end
    end else if (!nand_rb) begin
      bcnt++;
      if (bcnt >= busy_len) nand_rb = 1'b1;
    end
  end

  // bus timing monitors
  int wlow = 0, whigh = 1000, rlow = 0, rhigh = 1000, since_we = 1000, rb_hi = 1000;
  int sbad = 0, xbad = 0, rrbad = 0, whrbad = 0;
  always @(negedge clk) if (rst_n) begin
    if (!nand_we_n) begin
      if (wlow == 0 && (whigh < T_WH || rb_hi < T_RR)) begin
        if (whigh < T_WH) sbad++;
        if (rb_hi < T_RR) rrbad++;
      end
      wlow++; whigh = 0; since_we = 0;
    end else begin
      if (wlow != 0 && wlow != T_WP) sbad++;
      wlow = 0; whigh++; since_we++;
    end
    if (!nand_re_n) begin
      if (rlow == 0) begin
        if (rhigh < T_WH) sbad++;
        if (rb_hi < T_RR) rrbad++;
        if (since_we < T_WHR) whrbad++;
      end
      rlow++; rhigh = 0;
    end else begin
      if (rlow != 0 && rlow != T_WP) sbad++;
      rlow = 0; rhigh++;
    end
    if (nand_rb) rb_hi++; else rb_hi = 0;
    if ((nand_cle && nand_ale) || (!nand_we_n && !nand_re_n) || (nand_dq_oe && !nand_re_n)) xbad++;
  end

  int nchk = 0, nbad = 0, d13bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  logic [7:0] rdb [0:15];
  int         nrd, run_cyc;
  logic [1:0] run_res;

  task automatic run(input vec_t v);
    int widx = 0;
    bit got = 0;
    tr_clr++;
    stat_val = v.stat;
    wr_data = wpat(v.col, 0);
    nrd = 0; run_cyc = 0; run_res = 2'bxx;
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_col = v.col; req_page = v.page; req_len = v.len;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && run_cyc < 4000) begin
      if (rd_valid) begin
        if (nrd < 16) rdb[nrd] = rd_data;
        nrd++;
      end
      if (wr_take) begin widx++; wr_data = wpat(v.col, widx); end
      if (done) begin
        got = 1; run_res = result;
        if (!(nand_ce_n && req_ready)) d13bad++;
      end else begin
        @(negedge clk); run_cyc++;
      end
    end
    if (!got) chk(0, "R13 done never seen", 0, 1);
    @(negedge clk);
    if (done) d13bad++;
  endtask

  task automatic build_exp(input vec_t v, output int n);
    n = 0;
    case (v.op)
      3'd0, 3'd1: begin
        ex[n] = {2'd1, (v.op == 3'd0) ? 8'h00 : 8'h80}; n++;
        ex[n] = {2'd2, v.col[7:0]}; n++;
        ex[n] = {2'd2, 4'h0, v.col[11:8]}; n++;
        ex[n] = {2'd2, v.page[7:0]}; n++;
        ex[n] = {2'd2, v.page[15:8]}; n++;
        if (v.op == 3'd0) begin ex[n] = {2'd1, 8'h30}; n++; end
        else begin
          for (int i = 0; i < int'(v.len); i++) begin ex[n] = {2'd3, wpat(v.col, i)}; n++; end
          ex[n] = {2'd1, 8'h10}; n++;
          ex[n] = {2'd1, 8'h70}; n++;
        end
      end
      3'd2: begin
        ex[n] = {2'd1, 8'h60}; n++;
        ex[n] = {2'd2, v.page[7:0]}; n++;
        ex[n] = {2'd2, v.page[15:8]}; n++;
        ex[n] = {2'd1, 8'hD0}; n++;
        ex[n] = {2'd1, 8'h70}; n++;
      end
      3'd3: begin ex[n] = {2'd1, 8'h70}; n++; end
      3'd4: begin ex[n] = {2'd1, 8'hFF}; n++; end
      default: n = 0;
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R5 read";
      3'd1: return "R6 program";
      3'd2: return "R4 erase";
      3'd3: return "R10 status";
      3'd4: return "R11 reset";
      default: return "R9 bad op";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_col = '0; req_page = '0;
    req_len = 12'd1; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe
        && req_ready && !done, "R1 reset state",
        {24'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, req_ready, done},
        32'b11100010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 9; k++) begin
      vec_t v;
      int en, an, ern;
      bit tok, dok;
      v = VECS[k];
      run(v);
      chk(run_res == v.res, {tag_of(v.op), " result (R9)"}, run_res, v.res);
      build_exp(v, en);
      an = (tr_seen == tr_clr) ? trn : 0;
      tok = (an == en);
      for (int i = 0; i < en && i < 64; i++) if (tok && tr[i] != ex[i]) tok = 0;
      chk(tok, {tag_of(v.op), " bus trace R2/R3"}, an, en);
      ern = (v.op == 3'd0) ? int'(v.len) : (v.op <= 3'd3) ? 1 : 0;
      chk(nrd == ern, {tag_of(v.op), " read byte count"}, nrd, ern);
      dok = 1;
      for (int i = 0; i < nrd && i < 16; i++) begin
        logic [7:0] e;
        e = (v.op == 3'd0) ? pat(v.page, v.col + 12'(i)) : v.stat;
        if (rdb[i] != e) dok = 0;
      end
      chk(dok, {tag_of(v.op), " read bytes"}, (nrd > 0) ? rdb[0] : 8'h00,
          (v.op == 3'd0) ? pat(v.page, v.col) : v.stat);
      repeat (3) @(negedge clk);
    end

    // R7 busy timeout
    busy_len = 100000;
    run(VECS[0]);
    chk(run_res == 2'd2, "R7 timeout result", run_res, 2);
    chk(run_cyc >= T_TO, "R7 timeout not early", run_cyc, T_TO);
    chk(nand_ce_n == 1'b1, "R7 CE released", nand_ce_n, 1);
    busy_len = 20;
    repeat (30) @(negedge clk);
    run(VECS[6]);
    chk(run_res == 2'd0, "R7 recovery status", run_res, 0);

    chk(sbad == 0, "R8 strobe widths", sbad, 0);
    chk(xbad == 0, "R12 bus exclusivity", xbad, 0);
    chk(rrbad == 0, "R5 ready to strobe gap", rrbad, 0);
    chk(whrbad == 0, "R10 write to read gap", whrbad, 0);
    chk(d13bad == 0, "R13 done pulse", d13bad, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule